// File: doc/BRIEF.md
# Counted-Burst Complementary PWM Generator

This block drives a half-bridge with an exact number of whole PWM periods and then parks both gate drives low. An up-counting time base runs from zero to a programmed top value and wraps. A compare value splits each period into a low-side interval and a high-side interval. A dead-band stage holds off the rising edge of each gate, so the two switches never conduct together.

Software programs the period, compare, pulse count and the two dead times. It then pulses `start`. The block raises `busy` for the whole burst. The burst always finishes at a period boundary. A single-clock `done` pulse marks the end, and from the next clock both gates stay low. Period and compare inputs act as shadow values: they are taken at the start and at every wrap. A change in the middle of a period therefore never alters the pulse in progress.

Top module: `burst_pwm_gen`

## Requirements
- R1: After reset `busy`, `done`, `gate_hi` and `gate_lo` are all low.
- R2: While running, the counter steps 0,1,…,P and wraps to 0, so each period lasts P+1 clocks. A burst of N periods keeps `busy` high for exactly N·(P+1) clocks.
- R3: The raw high-side channel is set when the counter equals the compare value C and cleared when it equals P. The clear wins when both match. The raw channel is therefore high for P−C clocks of every period when C<P. The raw low-side channel is its complement while running.
- R4: Gates follow the raw channels one clock later. `gate_hi` is high for max(0, P−C−dead_rise) clocks per period. `gate_lo` is high for max(0, C+1−dead_fall) clocks per period. A dead time that is at least as long as the on-time suppresses that pulse rather than inverting it.
- R5: `gate_hi` and `gate_lo` are never high in the same clock.
- R6: The burst ends only at a period wrap after N whole periods. `done` is high for exactly one clock as `busy` falls. From the clock after `done` until the next start, both gates are low.
- R7: `period` and `compare` are captured at the start and at each wrap only. A change made mid-period first affects the following period.
- R8: A `start` pulse while `busy` is high is ignored. The burst length and the pulse count of the running burst do not change.
- R9: A start with `pulse_count` = 0 raises `done` one clock after the start edge. `busy` does not rise and neither gate toggles.
- R10: When P−C > dead_rise, `gate_hi` shows exactly N rising edges per burst, one complete pulse per period.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start | input | 1 | One-clock request to begin a burst |
| pulse_count | input | NUM_W | Number of whole periods in the burst |
| period | input | CNT_W | Counter top value P (shadow) |
| compare | input | CNT_W | Compare value C (shadow) |
| dead_rise | input | DT_W | Rising-edge delay of the high-side gate, clocks |
| dead_fall | input | DT_W | Rising-edge delay of the low-side gate, clocks |
| busy | output | 1 | High while a burst runs |
| done | output | 1 | One-clock pulse at burst end |
| gate_hi | output | 1 | High-side gate drive |
| gate_lo | output | 1 | Low-side gate drive |

## Verification
The burst function is tried over a set of period, compare, count and dead-time settings. Within that set:
- Balanced duty settings show that each period is whole and correctly split.
- A zero compare shows the extreme split.
- Dead times longer than the low-side or high-side on-time show that the pulse is suppressed rather than inverted.

For each setting, the bench counts busy clocks, gate high clocks, rising edges, overlaps and done clocks against closed-form expectations. Directed runs then cover the following:
- a zero count;
- a start during a burst;
- a mid-period change of period and compare, which tells shadow capture apart from immediate use;
- a quiet window after a burst, which shows that both gates rest low.

// File: rtl/burst_pwm_pkg.sv
package burst_pwm_pkg;
    parameter int unsigned DEF_CNT_W = 16;
    parameter int unsigned DEF_NUM_W = 16;
    parameter int unsigned DEF_DT_W  = 8;

    typedef enum logic [1:0] {
        ACT_HOLD = 2'd0,
        ACT_SET  = 2'd1,
        ACT_CLR  = 2'd2
    } act_e;
endpackage

// File: rtl/burst_timebase.sv
module burst_timebase
    import burst_pwm_pkg::*;
#(
    parameter int unsigned CNT_W = DEF_CNT_W,
    parameter int unsigned NUM_W = DEF_NUM_W
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start,
    input  logic [NUM_W-1:0] num_in,
    input  logic [CNT_W-1:0] prd_in,
    input  logic [CNT_W-1:0] cmp_in,
    output logic             busy,
    output logic             done,
    output logic             raw_a
);
    typedef struct packed {
        logic             busy;
        logic             done;
        logic [CNT_W-1:0] ctr;
        logic [CNT_W-1:0] prd;
        logic [CNT_W-1:0] cmp;
        logic [NUM_W-1:0] num;
        logic [NUM_W-1:0] seen;
        logic             raw_a;
    } tb_state_t;

    tb_state_t q, d;
    act_e      act;

    always_comb begin
        d      = q;
        d.done = 1'b0;
        act    = ACT_HOLD;
        if (!q.busy) begin
            d.raw_a = 1'b0;
            if (start) begin
                if (num_in == '0) begin
                    d.done = 1'b1;
                end else begin
                    d.busy  = 1'b1;
                    d.ctr   = '0;
                    d.prd   = prd_in;
                    d.cmp   = cmp_in;
                    d.num   = num_in;
                    d.seen  = '0;
                end
            end
        end else begin
            if (q.ctr == q.prd)      act = ACT_CLR;
            else if (q.ctr == q.cmp) act = ACT_SET;
            case (act)
                ACT_SET: d.raw_a = 1'b1;
                ACT_CLR: d.raw_a = 1'b0;
                default: d.raw_a = q.raw_a;
            endcase
            if (q.ctr == q.prd) begin
                d.ctr  = '0;
                d.prd  = prd_in;
                d.cmp  = cmp_in;
                d.seen = q.seen + NUM_W'(1);
                if (q.seen == q.num - NUM_W'(1)) begin
                    d.busy  = 1'b0;
                    d.done  = 1'b1;
                    d.raw_a = 1'b0;
                end
            end else begin
                d.ctr = q.ctr + CNT_W'(1);
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end

    assign busy  = q.busy;
    assign done  = q.done;
    assign raw_a = q.raw_a;

    // R2
    ctr_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
        q.busy |-> q.ctr <= q.prd);

    // R7
    shadow_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (q.busy && q.ctr != '0) |-> ($stable(q.cmp) && $stable(q.prd)));

    // R8
    start_ignored_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (q.busy && start && q.ctr != q.prd) |=>
        (q.busy && (q.ctr - CNT_W'(1)) == $past(q.ctr)));

    // R6
    idle_raw_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !q.busy |-> !q.raw_a);
endmodule

// File: rtl/burst_deadband.sv
module burst_deadband #(
    parameter int unsigned DT_W = 8
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            din,
    input  logic [DT_W-1:0] delay,
    output logic            dout
);
    localparam logic [DT_W-1:0] RUN_MAX = '1;

    typedef struct packed {
        logic [DT_W-1:0] run;
        logic            out;
    } db_state_t;

    db_state_t q, d;

    always_comb begin
        d.run = din ? ((q.run == RUN_MAX) ? q.run : q.run + DT_W'(1)) : '0;
        d.out = din && (q.run >= delay);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end

    assign dout = q.out;

    // R4
    fall_follow_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !din |=> !dout);
endmodule

// File: rtl/burst_pwm_gen.sv
module burst_pwm_gen
    import burst_pwm_pkg::*;
#(
    parameter int unsigned CNT_W = DEF_CNT_W,
    parameter int unsigned NUM_W = DEF_NUM_W,
    parameter int unsigned DT_W  = DEF_DT_W
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start,
    input  logic [NUM_W-1:0] pulse_count,
    input  logic [CNT_W-1:0] period,
    input  logic [CNT_W-1:0] compare,
    input  logic [DT_W-1:0]  dead_rise,
    input  logic [DT_W-1:0]  dead_fall,
    output logic             busy,
    output logic             done,
    output logic             gate_hi,
    output logic             gate_lo
);
    localparam int unsigned NCH = 2;

    logic            raw_a;
    logic [NCH-1:0]  raw_ch;
    logic [DT_W-1:0] dly_ch [NCH];
    logic [NCH-1:0]  gate_ch;

    burst_timebase #(.CNT_W(CNT_W), .NUM_W(NUM_W)) u_tb (
        .clk    (clk),
        .rst_n  (rst_n),
        .start  (start),
        .num_in (pulse_count),
        .prd_in (period),
        .cmp_in (compare),
        .busy   (busy),
        .done   (done),
        .raw_a  (raw_a)
    );

    assign raw_ch[0] = raw_a;
    assign raw_ch[1] = busy & ~raw_a;
    assign dly_ch[0] = dead_rise;
    assign dly_ch[1] = dead_fall;

    for (genvar ch = 0; ch < NCH; ch++) begin : g_db
        burst_deadband #(.DT_W(DT_W)) u_db (
            .clk   (clk),
            .rst_n (rst_n),
            .din   (raw_ch[ch]),
            .delay (dly_ch[ch]),
            .dout  (gate_ch[ch])
        );
    end

    assign gate_hi = gate_ch[0];
    assign gate_lo = gate_ch[1];

    // R5
    no_overlap_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(gate_hi && gate_lo));

    // R6
    done_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    // R6
    done_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> !busy);
endmodule

// File: tb/sim_burst_pwm_gen.sv
module sim_burst_pwm_gen;
    localparam int CLK_PER = 10;
    localparam int NV = 6;
    localparam int V_P  [NV] = '{20, 15, 12, 10, 180, 9};
    localparam int V_C  [NV] = '{10,  4,  3,  8,  90, 0};
    localparam int V_N  [NV] = '{ 3,  2,  4,  1,   5, 2};
    localparam int V_DR [NV] = '{ 2,  0,  3,  4,   4, 1};
    localparam int V_DF [NV] = '{ 2,  0,  5,  1,   4, 1};

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic start = 1'b0;
    logic [15:0] pulse_count = '0;
    logic [15:0] period = '0;
    logic [15:0] compare = '0;
    logic [7:0]  dead_rise = '0;
    logic [7:0]  dead_fall = '0;
    logic busy, done, gate_hi, gate_lo;

    int n_chk = 0;
    int n_fail = 0;
    logic clr = 1'b0;
    int hi_cnt, lo_cnt, rise_cnt, busy_cnt, done_cnt, ovl_cnt;
    logic prev_hi;

    always #(CLK_PER/2) clk = ~clk;

    burst_pwm_gen u0 (
        .clk(clk), .rst_n(rst_n), .start(start), .pulse_count(pulse_count),
        .period(period), .compare(compare), .dead_rise(dead_rise),
        .dead_fall(dead_fall), .busy(busy), .done(done),
        .gate_hi(gate_hi), .gate_lo(gate_lo)
    );

    always @(negedge clk) begin
        if (clr) begin
            hi_cnt = 0; lo_cnt = 0; rise_cnt = 0;
            busy_cnt = 0; done_cnt = 0; ovl_cnt = 0;
            prev_hi = gate_hi;
        end else begin
            hi_cnt   += int'(gate_hi);
            lo_cnt   += int'(gate_lo);
            busy_cnt += int'(busy);
            done_cnt += int'(done);
            if (gate_hi && gate_lo) ovl_cnt++;
            if (gate_hi && !prev_hi) rise_cnt++;
            prev_hi = gate_hi;
        end
    end

    task automatic chk(input string req, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic tick();
        @(posedge clk); #1;
    endtask

    task automatic setup(input int p, input int c, input int n, input int dr, input int df);
        period = 16'(p); compare = 16'(c); pulse_count = 16'(n);
        dead_rise = 8'(dr); dead_fall = 8'(df);
        clr = 1'b1; tick(); clr = 1'b0;
    endtask

    task automatic pulse_start();
        start = 1'b1; tick(); start = 1'b0;
    endtask

    task automatic wait_done();
        for (int k = 0; k < 5000 && done_cnt == 0; k++) tick();
        repeat (4) tick();
    endtask

    function automatic int pos(input int v);
        return (v > 0) ? v : 0;
    endfunction

    initial begin
        #(CLK_PER * 200000);
        n_fail++;
        $display("FAIL watchdog: actual hung expected finish");
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
        $finish;
    end

    initial begin
        repeat (3) tick();
        // R1 reset state
        chk("R1 busy", int'(busy), 0);
        chk("R1 done", int'(done), 0);
        chk("R1 gates", int'(gate_hi) + int'(gate_lo), 0);
        rst_n = 1'b1;
        repeat (2) tick();

        for (int v = 0; v < NV; v++) begin
            int h, l;
            h = V_P[v] - V_C[v];
            l = V_C[v] + 1;
            setup(V_P[v], V_C[v], V_N[v], V_DR[v], V_DF[v]);
            pulse_start();
            wait_done();
            chk("R2 busy length", busy_cnt, V_N[v] * (V_P[v] + 1));
            chk("R3 R4 gate_hi time", hi_cnt, V_N[v] * pos(h - V_DR[v]));
            chk("R4 gate_lo time", lo_cnt, V_N[v] * pos(l - V_DF[v]));
            chk("R10 gate_hi pulses", rise_cnt, (h > V_DR[v]) ? V_N[v] : 0);
            chk("R5 overlap", ovl_cnt, 0);
            chk("R6 done width", done_cnt, 1);
        end

        // R9 zero count
        setup(10, 5, 0, 0, 0);
        start = 1'b1; @(posedge clk); @(negedge clk);
        chk("R9 done after start", int'(done), 1);
        #1 start = 1'b0;
        repeat (5) tick();
        chk("R9 no busy", busy_cnt, 0);
        chk("R9 no gates", hi_cnt + lo_cnt, 0);

        // R8 start during burst
        setup(10, 5, 3, 0, 0);
        pulse_start();
        repeat (7) tick();
        pulse_count = 16'd1;
        pulse_start();
        wait_done();
        chk("R8 busy length", busy_cnt, 33);
        chk("R8 pulses", rise_cnt, 3);

        // R7 shadow capture: change mid first period
        setup(10, 2, 2, 0, 0);
        pulse_start();
        repeat (3) tick();
        period = 16'd14; compare = 16'd7;
        wait_done();
        chk("R7 busy length", busy_cnt, 11 + 15);
        chk("R7 gate_hi time", hi_cnt, 8 + 7);
        chk("R7 gate_lo time", lo_cnt, 3 + 8);

        // R6 quiet after burst
        setup(10, 2, 1, 0, 0);
        repeat (20) tick();
        chk("R6 idle gates", hi_cnt + lo_cnt, 0);
        chk("R6 idle busy", busy_cnt, 0);

        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
        $finish;
    end
endmodule